// File: doc/BRIEF.md
# DDR Auto-Precharge Command Legality Checker

This block watches the command bus of a single-rank, four-bank DDR SDRAM and rules on every command it samples: legal or illegal for the bank it targets. Its main concern is what may follow a write that closes its row by itself (a write with auto-precharge). After such a write, the verdict depends on the exact number of cycles since the write and on whether the new command goes to the same bank or to another one. A read that cuts into such a write is only allowed if the write's remaining data is masked, and the block flags that case.

Each bank has its own timer. The timer covers the end of the 4-beat burst, the write recovery time, the internal precharge and the row precharge time. Outside the six-cycle window that follows a write with auto-precharge, the timer state of the target bank alone decides. The block is meant to sit beside a memory controller, either as a protocol checker or as a helper that tells an arbiter which candidate commands may issue. Burst length is 4 and write latency is one cycle. Refresh, mode programming and the data path are not modelled.

Top module: `ddr_ap_legality_chk`

## Requirements
- R1: The auto-precharge flag is address bit 8 (`addr_i[8]`). A write with that bit low leaves the row open, so later reads to that bank are legal at any offset and an activate stays illegal.
- R2: Command codes on `cmd_i` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 deselect. The verdict for a command sampled on one rising edge appears on `legal_o`/`mask_o` after that edge. Reset gives `legal_o`=1 and `mask_o`=0.
- R3: No-op and deselect are always legal, never raise `mask_o`, and never change any bank's state, whatever the bank and address inputs hold.
- R4: Exactly 1 cycle after an accepted write with auto-precharge, only a write to the same bank is legal.
- R5: 2 or 3 cycles after it, same-bank writes are legal. Same-bank reads (either flag value) are legal with `mask_o`=1. Activate and precharge are illegal.
- R6: 4 or 5 cycles after it, only same-bank reads are legal, with `mask_o`=0.
- R7: 6 cycles after it, every same-bank command is illegal.
- R8: While any other bank is 1 to 3 cycles past its write with auto-precharge, a read is illegal. From 4 cycles on it is legal. Writes, activates and precharges to a different bank are never blocked by another bank's window.
- R9: After a write with auto-precharge, the bank is busy until the burst (WL+BL/2 = 3 cycles), TWR and TRP have run out. An activate becomes legal exactly WL+BL/2+TWR+TRP+1 = 9 cycles after the write. An explicit precharge makes an activate legal TRP+1 = 4 cycles later.
- R10: Outside any window, an activate is legal only to an idle bank. Reads and writes are legal only to an open bank. A precharge is legal to an open or idle bank.
- R11: Codes 6 and 7 are reserved and always illegal. An illegal command changes no bank state.
- R12: A read with auto-precharge to an open bank makes an activate to that bank legal exactly BL/2+TRP+1 = 6 cycles later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code sampled each cycle |
| bank_i | input | BANK_W (2) | Target bank of the command |
| addr_i | input | ADDR_W (12) | Address bus; bit AP_BIT carries the auto-precharge flag |
| legal_o | output | 1 | Registered verdict for the previous command |
| mask_o | output | 1 | Registered flag: the legal read needs the interrupted write masked |

## Verification
Both results are due exactly one rising edge after the command is sampled, because a single output register sits between the decision and the pins. The bench drives one command per cycle on the falling edge and queues the expected verdict at the same moment. A monitor pops one entry a short delay after each following rising edge, so entry and result always meet on the same clock. Window probes are placed by counting no-ops from the write (slot k is the k-th command after it), and enough no-ops follow each probe for every bank to return to idle before the next case.

// File: rtl/ddr_ap_pkg.sv
package ddr_ap_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_DESEL = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_WREC  = 2'd2,
    BK_PRECH = 2'd3
  } bank_st_e;

  // slot window after a write with auto-precharge
  localparam int SLOT_W          = 3;
  localparam int SLOT_WIN        = 6;  // last slot of the window
  localparam int SLOT_WR_LAST    = 3;  // same-bank writes legal up to here
  localparam int SLOT_MASK_FIRST = 2;  // same-bank reads legal from here
  localparam int SLOT_RD_LAST    = 5;  // same-bank reads legal up to here
  localparam int SLOT_XRD_LAST   = 3;  // reads to other banks blocked up to here

endpackage

// File: rtl/ddr_ap_bank_timer.sv
module ddr_ap_bank_timer
  import ddr_ap_pkg::*;
#(
  parameter int TWR = 2,
  parameter int TRP = 3,
  parameter int BL  = 4,
  parameter int WL  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_i,   // legal non-idle command for this bank
  input  cmd_e              cmd_i,
  input  logic              ap_i,
  output bank_st_e          st_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam int BURST_CYC = WL + BL / 2;
  localparam int WR_SPAN   = BURST_CYC + TWR;
  localparam int RD_SPAN   = BL / 2 + TRP;
  localparam int SPAN_MAX  = (WR_SPAN > RD_SPAN) ?
                             ((WR_SPAN > TRP) ? WR_SPAN : TRP) :
                             ((RD_SPAN > TRP) ? RD_SPAN : TRP);
  localparam int CNT_W     = $clog2(SPAN_MAX + 1);

  bank_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic              cnt_last;

  assign cnt_last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= BK_IDLE;
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      // window slot advance
      if (slot_q != '0)
        slot_q <= (slot_q == SLOT_W'(SLOT_WIN)) ? '0 : slot_q + SLOT_W'(1);

      // timer countdown
      case (st_q)
        BK_WREC: begin
          if (cnt_last) begin
            st_q  <= BK_PRECH;
            cnt_q <= CNT_W'(TRP);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        BK_PRECH: begin
          if (cnt_last) st_q <= BK_IDLE;
          else          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: ;
      endcase

      // accepted command overrides
      if (acc_i) begin
        case (cmd_i)
          CMD_ACT: st_q <= BK_OPEN;
          CMD_PRE: begin
            st_q  <= BK_PRECH;
            cnt_q <= CNT_W'(TRP);
          end
          CMD_WR: begin
            if (ap_i || st_q == BK_WREC) begin
              st_q   <= BK_WREC;
              cnt_q  <= CNT_W'(WR_SPAN);
              slot_q <= SLOT_W'(1);
            end
          end
          CMD_RD: begin
            if (ap_i && st_q == BK_OPEN) begin
              st_q  <= BK_PRECH;
              cnt_q <= CNT_W'(RD_SPAN);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign st_o   = st_q;
  assign slot_o = slot_q;

endmodule

// File: rtl/ddr_ap_rules.sv
module ddr_ap_rules
  import ddr_ap_pkg::*;
(
  input  cmd_e              cmd_i,
  input  bank_st_e          st_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              xblock_i,
  output logic              legal_o,
  output logic              mask_o
);

  logic in_win;
  assign in_win = (slot_i != '0);

  always_comb begin
    legal_o = 1'b0;
    mask_o  = 1'b0;
    if (in_win) begin
      case (cmd_i)
        CMD_NOP, CMD_DESEL: legal_o = 1'b1;
        CMD_WR: legal_o = (slot_i <= SLOT_W'(SLOT_WR_LAST));
        CMD_RD: begin
          legal_o = (slot_i >= SLOT_W'(SLOT_MASK_FIRST)) &&
                    (slot_i <= SLOT_W'(SLOT_RD_LAST));
          mask_o  = legal_o && (slot_i <= SLOT_W'(SLOT_WR_LAST));
        end
        default: legal_o = 1'b0;
      endcase
    end else begin
      case (cmd_i)
        CMD_NOP, CMD_DESEL: legal_o = 1'b1;
        CMD_ACT:            legal_o = (st_i == BK_IDLE);
        CMD_RD, CMD_WR:     legal_o = (st_i == BK_OPEN);
        CMD_PRE:            legal_o = (st_i == BK_OPEN) || (st_i == BK_IDLE);
        default:            legal_o = 1'b0;
      endcase
    end
    if (cmd_i == CMD_RD && xblock_i) begin
      legal_o = 1'b0;
      mask_o  = 1'b0;
    end
  end

endmodule

// File: rtl/ddr_ap_xbank.sv
module ddr_ap_xbank
  import ddr_ap_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  logic [NBANK-1:0][SLOT_W-1:0] slot_i,
  input  logic [BANK_W-1:0]            bank_i,
  output logic                         xblock_o
);

  logic [NBANK-1:0] early;
  logic [NBANK-1:0] self_sel;

  for (genvar g = 0; g < NBANK; g++) begin : g_early
    assign early[g]    = (slot_i[g] != '0) && (slot_i[g] <= SLOT_W'(SLOT_XRD_LAST));
    assign self_sel[g] = (bank_i == BANK_W'(g));
  end

  assign xblock_o = |(early & ~self_sel);

endmodule

// File: rtl/ddr_ap_legality_chk.sv
module ddr_ap_legality_chk
  import ddr_ap_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 8,
  parameter int TWR    = 2,
  parameter int TRP    = 3,
  parameter int BL     = 4,
  parameter int WL     = 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              legal_o,
  output logic              mask_o
);

  cmd_e                         cmd_c;
  logic                         ap_c;
  logic                         busy_cmd;
  bank_st_e                     st_v [NBANK];
  logic [NBANK-1:0][SLOT_W-1:0] slot_v;
  logic [NBANK-1:0]             acc_v;
  bank_st_e                     st_sel;
  logic [SLOT_W-1:0]            slot_sel;
  logic                         xblock;
  logic                         legal_c;
  logic                         mask_c;
  logic                         legal_q;
  logic                         mask_q;

  assign cmd_c    = cmd_e'(cmd_i);
  assign ap_c     = addr_i[AP_BIT];
  assign busy_cmd = (cmd_c != CMD_NOP) && (cmd_c != CMD_DESEL);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign acc_v[g] = legal_c && busy_cmd && (bank_i == BANK_W'(g));

    ddr_ap_bank_timer #(
      .TWR (TWR),
      .TRP (TRP),
      .BL  (BL),
      .WL  (WL)
    ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .acc_i  (acc_v[g]),
      .cmd_i  (cmd_c),
      .ap_i   (ap_c),
      .st_o   (st_v[g]),
      .slot_o (slot_v[g])
    );
  end

  assign st_sel   = st_v[bank_i];
  assign slot_sel = slot_v[bank_i];

  ddr_ap_xbank #(
    .NBANK  (NBANK),
    .BANK_W (BANK_W)
  ) u_xbank (
    .slot_i   (slot_v),
    .bank_i   (bank_i),
    .xblock_o (xblock)
  );

  ddr_ap_rules u_rules (
    .cmd_i    (cmd_c),
    .st_i     (st_sel),
    .slot_i   (slot_sel),
    .xblock_i (xblock),
    .legal_o  (legal_c),
    .mask_o   (mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      legal_q <= 1'b1;
      mask_q  <= 1'b0;
    end else begin
      legal_q <= legal_c;
      mask_q  <= mask_c;
    end
  end

  assign legal_o = legal_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/ddr_ap_legality_sva.sv
module ddr_ap_legality_sva #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              legal_o,
  input logic              mask_o
);

  localparam logic [2:0] C_NOP = 3'd0;
  localparam logic [2:0] C_ACT = 3'd1;
  localparam logic [2:0] C_RD  = 3'd2;
  localparam logic [2:0] C_WR  = 3'd3;
  localparam logic [2:0] C_DES = 3'd5;

  logic [1:0] armed;
  always_ff @(posedge clk) begin
    if (rst)               armed <= 2'd0;
    else if (armed != 2'd3) armed <= armed + 2'd1;
  end

  p_reset_state_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (legal_o && !mask_o));

  p_idle_cmd_legal_r3: assert property (@(posedge clk) disable iff (rst || armed == 2'd0)
    ($past(cmd_i) == C_NOP || $past(cmd_i) == C_DES) |-> (legal_o && !mask_o));

  p_mask_on_read_r5: assert property (@(posedge clk) disable iff (rst || armed == 2'd0)
    mask_o |-> (legal_o && $past(cmd_i) == C_RD));

  p_reserved_illegal_r11: assert property (@(posedge clk) disable iff (rst || armed == 2'd0)
    (cmd_i[2:1] == 2'b11) |=> (!legal_o && !mask_o));

  p_slot1_no_act_r4: assert property (@(posedge clk) disable iff (rst || armed == 2'd0)
    ($past(cmd_i) == C_WR && $past(addr_i[AP_BIT]) && legal_o &&
     cmd_i == C_ACT && bank_i == $past(bank_i)) |=> !legal_o);

  p_slot1_xbank_rd_r8: assert property (@(posedge clk) disable iff (rst || armed == 2'd0)
    ($past(cmd_i) == C_WR && $past(addr_i[AP_BIT]) && legal_o &&
     cmd_i == C_RD && bank_i != $past(bank_i)) |=> !legal_o);

endmodule

bind ddr_ap_legality_chk ddr_ap_legality_sva #(
  .BANK_W (BANK_W),
  .ADDR_W (ADDR_W),
  .AP_BIT (AP_BIT)
) u_sva (
  .clk     (clk),
  .rst     (rst),
  .cmd_i   (cmd_i),
  .bank_i  (bank_i),
  .addr_i  (addr_i),
  .legal_o (legal_o),
  .mask_o  (mask_o)
);

// File: tb/ddr_ap_legality_chk_tb.sv
module ddr_ap_legality_chk_tb;

  localparam int PERIOD = 10;
  localparam int WD_CYC = 20000;

  localparam logic [2:0] NOP = 3'd0;
  localparam logic [2:0] ACT = 3'd1;
  localparam logic [2:0] RD  = 3'd2;
  localparam logic [2:0] WR  = 3'd3;
  localparam logic [2:0] PRE = 3'd4;
  localparam logic [2:0] DES = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = NOP;
  logic [1:0]  bank = 2'd0;
  logic [11:0] addr = '0;
  logic        legal;
  logic        mask;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic  el;
    logic  em;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t m_item;

  always #(PERIOD / 2) clk = ~clk;

  ddr_ap_legality_chk u_dut (
    .clk     (clk),
    .rst     (rst),
    .cmd_i   (cmd),
    .bank_i  (bank),
    .addr_i  (addr),
    .legal_o (legal),
    .mask_o  (mask)
  );

  task automatic issue(input logic [2:0] c, input int b, input logic ap,
                       input logic el, input logic em, input string tag);
    exp_t it;
    @(negedge clk);
    cmd  = c;
    bank = 2'(b);
    addr = ap ? 12'h100 : 12'h000;
    it.el = el; it.em = em; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) issue(NOP, i % 4, i[0], 1'b1, 1'b0, "R3");
  endtask

  // expected same-bank verdict k cycles after a write with auto-precharge
  function automatic void same_exp(input int k, input logic [2:0] c,
                                   output logic l, output logic m);
    l = 1'b0; m = 1'b0;
    if (c == WR) l = (k <= 3);
    if (c == RD) begin
      l = (k >= 2 && k <= 5);
      m = (k <= 3) && l;
    end
  endfunction

  function automatic string slot_tag(input int k);
    if (k == 1) return "R4";
    if (k <= 3) return "R5";
    if (k <= 5) return "R6";
    return "R7";
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: one result per queued command, read after the next rising edge
  always @(posedge clk) begin
    #(PERIOD / 5);
    if (exp_q.size() > 0) begin
      m_item = exp_q.pop_front();
      n_cmp++;
      if (legal !== m_item.el || mask !== m_item.em) begin
        n_bad++;
        $display("FAIL %s: legal=%b mask=%b expected legal=%b mask=%b",
                 m_item.tag, legal, mask, m_item.el, m_item.em);
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run not finished, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic el, em;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    n_cmp++;
    if (legal !== 1'b1 || mask !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: legal=%b mask=%b expected legal=1 mask=0", legal, mask);
    end

    // R1 / R10 / R9: plain write keeps row open, explicit precharge timing
    issue(ACT, 0, 0, 1, 0, "R10");
    issue(NOP, 0, 0, 1, 0, "R3");
    issue(WR,  0, 0, 1, 0, "R1");
    issue(RD,  0, 0, 1, 0, "R1");
    issue(ACT, 0, 0, 0, 0, "R1");
    issue(RD,  2, 0, 0, 0, "R10");
    issue(PRE, 0, 0, 1, 0, "R10");
    nop(2);
    issue(ACT, 0, 0, 0, 0, "R9");
    issue(ACT, 0, 0, 1, 0, "R9");
    issue(PRE, 0, 0, 1, 0, "R10");
    nop(4);

    // R4..R7: same-bank slot table
    for (int k = 1; k <= 6; k++) begin
      for (int ci = 0; ci < 4; ci++) begin
        logic [2:0] pc;
        pc = (ci == 0) ? WR : (ci == 1) ? RD : (ci == 2) ? ACT : PRE;
        issue(ACT, 0, 0, 1, 0, "R10");
        issue(WR,  0, 1, 1, 0, "R1");
        nop(k - 1);
        same_exp(k, pc, el, em);
        issue(pc, 0, k[0], el, em, slot_tag(k));
        nop(12);
      end
    end

    // R8: other-bank reads by slot, other-bank write and activate unaffected
    issue(ACT, 1, 0, 1, 0, "R10");
    for (int k = 1; k <= 6; k++) begin
      issue(ACT, 0, 0, 1, 0, "R10");
      issue(WR,  0, 1, 1, 0, "R1");
      nop(k - 1);
      issue(RD, 1, 0, (k >= 4), 0, "R8");
      nop(12);
    end
    issue(ACT, 0, 0, 1, 0, "R10");
    issue(WR,  0, 1, 1, 0, "R1");
    issue(WR,  1, 0, 1, 0, "R8");
    issue(ACT, 3, 0, 1, 0, "R8");
    nop(12);
    issue(PRE, 3, 0, 1, 0, "R10");
    nop(4);

    // R9: busy span after write with auto-precharge
    issue(ACT, 2, 0, 1, 0, "R10");
    issue(WR,  2, 1, 1, 0, "R1");
    nop(6);
    issue(RD,  2, 0, 0, 0, "R9");
    issue(ACT, 2, 0, 0, 0, "R9");
    issue(ACT, 2, 0, 1, 0, "R9");

    // R12: read with auto-precharge
    issue(ACT, 3, 0, 1, 0, "R10");
    issue(RD,  3, 1, 1, 0, "R12");
    nop(4);
    issue(ACT, 3, 0, 0, 0, "R12");
    issue(ACT, 3, 0, 1, 0, "R12");

    // R11 / R3: reserved codes, illegal and idle commands change nothing
    issue(3'd6, 0, 1, 0, 0, "R11");
    issue(3'd7, 0, 0, 0, 0, "R11");
    issue(ACT,  0, 0, 1, 0, "R11");
    issue(ACT,  0, 0, 0, 0, "R11");
    issue(RD,   0, 0, 1, 0, "R11");
    issue(DES,  0, 1, 1, 0, "R3");
    issue(DES,  0, 0, 1, 0, "R3");
    issue(RD,   0, 0, 1, 0, "R3");
    nop(2);

    repeat (3) @(posedge clk);
    #(PERIOD / 2);
    done = 1;
    summary();
    $finish;
  end

endmodule